// File: doc/BRIEF.md
# Serial Port Bus Register and Interrupt Unit

This block is the processor-facing half of a byte-oriented serial port. An APB slave port selects one of five word-aligned registers: data, status, control, baud scaler and FIFO debug. Behind the registers sit two byte FIFOs. One queues bytes the processor writes for transmission. The other queues bytes the serial engine delivers. A separate serial engine does the bit timing, parity and framing. It takes transmit bytes through a pop handshake, delivers received bytes through a push strobe, and reports framing, parity and break conditions through single-cycle strobes.

The status word combines four kinds of information: both FIFO fill counts in its top bits, full and half-full flags, four sticky error flags, and the data-ready and transmit-empty indications. One interrupt line combines six enabled sources. Two are level sources: received data present, and received data at half the FIFO depth or more. Another level source is transmit space, meaning the transmit FIFO is below half full. Break and "transmitter fully idle" are also level sources. The transmit interrupt is different: it is a one-cycle event that fires when the transmit FIFO drains from non-empty to empty. In debug mode, software can write bytes straight into the receive FIFO.

Top module: `sio_bus_front`

## Requirements
- R1: After reset, the control register reads 0x80000000 (bit 31 = FIFOs present, read-only; all enables, flow control and the other fields are 0). The status register reads 0x00000006 while the engine reports its shift register empty. The interrupt output is low.
- R2: A write to the data register (offset 0x00) queues pwdata[7:0] in the transmit FIFO. The engine receives the bytes in write order on tx_byte, one byte per tx_pop cycle. The transmit count appears in status bits 25:20. Status bit 2 is set only while that count is 0.
- R3: While the transmit FIFO holds DEPTH bytes, status bit 9 is set and a data write is discarded.
- R4: A byte pushed by the engine enters the receive FIFO. The receive count appears in status bits 31:26. Status bit 0 is set while the count is non-zero. A read of the data register returns the oldest byte in bits 7:0 and removes it. A read while the FIFO is empty returns 0 and changes nothing.
- R5: An engine push while the receive FIFO is full is dropped and sets the sticky overrun flag (status bit 4). Status bit 10 flags the full receive FIFO.
- R6: Framing, parity and break strobes set sticky status bits 6, 5 and 3. Any write to the status register (offset 0x04) clears bits 6, 5, 4 and 3.
- R7: Status bit 8 (receive) and status bit 7 (transmit) are set while the matching FIFO holds DEPTH/2 bytes or more.
- R8: With control bit 3 set, the interrupt pulses high for exactly one cycle after the pop that empties the transmit FIFO. It does not pulse while bytes remain.
- R9: With control bit 2 set, the interrupt is high for as long as the receive FIFO is not empty.
- R10: The interrupt is also high under each of these conditions:
  - control bit 10 is set and receive status bit 8 is set;
  - control bit 9 is set and the transmit FIFO holds fewer than DEPTH/2 bytes;
  - control bit 12 is set and the break flag is set;
  - control bit 14 is set, the transmit FIFO is empty and the shift register is empty.
- R11: A write to the debug register (offset 0x10) pushes pwdata[7:0] into the receive FIFO only while control bit 11 is set. Otherwise it has no effect.
- R12: Control bits 14:0 and scaler bits 11:0 (offset 0x0C) read back what was written and drive cfg_ctrl and cfg_scaler. Control bits 30:15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_avail | output | 1 | Transmit FIFO not empty |
| tx_pop | input | 1 | Engine takes tx_byte |
| tx_shift_empty | input | 1 | Engine shift register is empty |
| rx_push | input | 1 | Engine delivers rx_byte |
| rx_byte | input | 8 | Received byte |
| err_frame | input | 1 | Framing error strobe |
| err_parity | input | 1 | Parity error strobe |
| err_break | input | 1 | Break strobe |
| cfg_ctrl | output | 15 | Control bits 14:0 |
| cfg_scaler | output | SCALER_W | Scaler reload value |
| irq | output | 1 | Combined interrupt |

## Verification
The transmit path is driven with short bursts and with a burst one byte over the depth. The short bursts show that ordering is kept. The oversized burst shows that the dropped byte never reaches the engine. The receive path is filled partly, filled to the threshold, and then overfilled. These fills separate the half, full and overrun flags. An empty read separates the data-ready logic from the count. Each interrupt source is enabled alone, and its condition is toggled both on and off. This shows that the level sources follow state, while the transmit source fires only on the drain edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
   // word index of each register (byte address bits 4:2)
   localparam int REG_DATA   = 0;
   localparam int REG_STATUS = 1;
   localparam int REG_CTRL   = 2;
   localparam int REG_SCALER = 3;
   localparam int REG_DEBUG  = 4;
   // control bit positions
   localparam int CTRL_W     = 15;
   localparam int CB_RX_IE   = 2;
   localparam int CB_TX_IE   = 3;
   localparam int CB_TXL_IE  = 9;
   localparam int CB_RXL_IE  = 10;
   localparam int CB_DEBUG   = 11;
   localparam int CB_BRK_IE  = 12;
   localparam int CB_IDLE_IE = 14;
   typedef logic [7:0] byte_t;
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
   parameter int DEPTH = 8,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  sio_pkg::byte_t  din,
   input  logic            pop,
   output sio_pkg::byte_t  head,
   output logic [CW-1:0]   count,
   output logic            full,
   output logic            empty
);
   logic [PW-1:0]  wr_ptr, rd_ptr;
   sio_pkg::byte_t mem [DEPTH];
   logic           do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (do_push && wr_ptr == PW'(i)) mem[i] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [sio_pkg::CTRL_W-1:0] en,
   input  logic                      rx_ready,
   input  logic                      rx_half,
   input  logic                      tx_half,
   input  logic                      tx_empty,
   input  logic                      shift_empty,
   input  logic                      brk,
   output logic                      irq
);
   import sio_pkg::*;
   logic was_busy_q, drained;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) was_busy_q <= 1'b0;
      else        was_busy_q <= ~tx_empty;
   end

   assign drained = was_busy_q & tx_empty;

   assign irq = (en[CB_RX_IE]   & rx_ready)
              | (en[CB_TX_IE]   & drained)
              | (en[CB_RXL_IE]  & rx_half)
              | (en[CB_TXL_IE]  & ~tx_half)
              | (en[CB_BRK_IE]  & brk)
              | (en[CB_IDLE_IE] & tx_empty & shift_empty);
endmodule

// File: rtl/sio_bus_front.sv
module sio_bus_front #(
   parameter int DEPTH    = 8,
   parameter int ADDR_W   = 5,
   parameter int SCALER_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [31:0]         pwdata,
   output logic [31:0]         prdata,
   output logic                pready,
   output logic                pslverr,
   output logic [7:0]          tx_byte,
   output logic                tx_avail,
   input  logic                tx_pop,
   input  logic                tx_shift_empty,
   input  logic                rx_push,
   input  logic [7:0]          rx_byte,
   input  logic                err_frame,
   input  logic                err_parity,
   input  logic                err_break,
   output logic [14:0]         cfg_ctrl,
   output logic [SCALER_W-1:0] cfg_scaler,
   output logic                irq
);
   import sio_pkg::*;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int HALF = DEPTH / 2;

   if (DEPTH < 2 || DEPTH > 32 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two from 2 to 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover five word registers");
   end
   if (SCALER_W < 1 || SCALER_W > 31) begin : g_bad_scaler
      $error("SCALER_W out of range");
   end

   logic              wr_acc, rd_acc, tx_wr, rx_rd, dbg_wr;
   logic [2:0]        reg_sel;
   logic [CTRL_W-1:0] ctrl_q;
   logic [SCALER_W-1:0] scaler_q;
   logic              fe_q, pe_q, ov_q, br_q;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   byte_t             tx_head, rx_head, rx_din;
   logic              rx_in;
   logic [31:0]       status;
   logic              unused_bits;

   assign unused_bits = &{1'b0, paddr, pwdata};
   assign pready  = 1'b1;
   assign pslverr = 1'b0;
   assign reg_sel = paddr[4:2];
   assign wr_acc  = psel & penable & pwrite;
   assign rd_acc  = psel & penable & ~pwrite;
   assign tx_wr   = wr_acc & (reg_sel == 3'(REG_DATA));
   assign rx_rd   = rd_acc & (reg_sel == 3'(REG_DATA));
   assign dbg_wr  = wr_acc & (reg_sel == 3'(REG_DEBUG)) & ctrl_q[CB_DEBUG];
   // engine delivery has priority over a debug write in the same cycle
   assign rx_in   = rx_push | dbg_wr;
   assign rx_din  = rx_push ? rx_byte : pwdata[7:0];

   sio_byte_fifo #(.DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(pwdata[7:0]), .pop(tx_pop),
      .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

   sio_byte_fifo #(.DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_in), .din(rx_din), .pop(rx_rd),
      .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         scaler_q <= '0;
         fe_q <= 1'b0; pe_q <= 1'b0; ov_q <= 1'b0; br_q <= 1'b0;
      end else begin
         if (wr_acc && reg_sel == 3'(REG_CTRL))   ctrl_q   <= pwdata[CTRL_W-1:0];
         if (wr_acc && reg_sel == 3'(REG_SCALER)) scaler_q <= pwdata[SCALER_W-1:0];
         if (wr_acc && reg_sel == 3'(REG_STATUS)) begin
            fe_q <= 1'b0; pe_q <= 1'b0; ov_q <= 1'b0; br_q <= 1'b0;
         end
         // new events win over a clear in the same cycle
         if (err_frame)           fe_q <= 1'b1;
         if (err_parity)          pe_q <= 1'b1;
         if (err_break)           br_q <= 1'b1;
         if (rx_push && rx_full)  ov_q <= 1'b1;
      end
   end

   always_comb begin
      status        = '0;
      status[31:26] = 6'(rx_cnt);
      status[25:20] = 6'(tx_cnt);
      status[10]    = rx_full;
      status[9]     = tx_full;
      status[8]     = (rx_cnt >= CW'(HALF));
      status[7]     = (tx_cnt >= CW'(HALF));
      status[6]     = fe_q;
      status[5]     = pe_q;
      status[4]     = ov_q;
      status[3]     = br_q;
      status[2]     = tx_empty;
      status[1]     = tx_shift_empty;
      status[0]     = ~rx_empty;
   end

   always_comb begin
      case (reg_sel)
         3'(REG_DATA):   prdata = rx_empty ? 32'd0 : {24'd0, rx_head};
         3'(REG_STATUS): prdata = status;
         3'(REG_CTRL):   prdata = {1'b1, 16'd0, ctrl_q};
         3'(REG_SCALER): prdata = 32'(scaler_q);
         3'(REG_DEBUG):  prdata = {24'd0, tx_head};
         default:        prdata = 32'd0;
      endcase
   end

   assign tx_byte    = tx_head;
   assign tx_avail   = ~tx_empty;
   assign cfg_ctrl   = ctrl_q;
   assign cfg_scaler = scaler_q;

   sio_irq_gen u_irq (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q),
      .rx_ready(~rx_empty), .rx_half(status[8]), .tx_half(status[7]),
      .tx_empty(tx_empty), .shift_empty(tx_shift_empty), .brk(br_q),
      .irq(irq));
endmodule

// File: rtl/sio_bus_front_chk.sv
module sio_bus_front_chk #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt,
   input logic          tx_wr,
   input logic          tx_pop,
   input logic          rx_rd,
   input logic          rx_push,
   input logic          ov_q,
   input logic [14:0]   ctrl_q,
   input logic          irq
);
   AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH)); // R2
   AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == CW'(DEPTH) && tx_wr && !tx_pop) |=> tx_cnt == CW'(DEPTH)); // R3
   AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0); // R4
   AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_cnt == CW'(DEPTH)) |=> ov_q); // R5
   AST_TX_DRAIN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3] && $past(tx_cnt) != '0 && tx_cnt == '0) |-> irq); // R8
   AST_RX_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[2] && rx_cnt != '0) |-> irq); // R9
endmodule

bind sio_bus_front sio_bus_front_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
   .tx_wr(tx_wr), .tx_pop(tx_pop), .rx_rd(rx_rd), .rx_push(rx_push),
   .ov_q(ov_q), .ctrl_q(ctrl_q), .irq(irq));

// File: tb/sim_sio_bus_front.sv
`timescale 1ns/1ps
module sim_sio_bus_front;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        psel = 0, penable = 0, pwrite = 0;
   logic [4:0]  paddr = '0;
   logic [31:0] pwdata = '0, prdata;
   logic        pready, pslverr;
   logic [7:0]  tx_byte, rx_byte = '0;
   logic        tx_avail, tx_pop = 0, tx_shift_empty = 1;
   logic        rx_push = 0, err_frame = 0, err_parity = 0, err_break = 0;
   logic [14:0] cfg_ctrl;
   logic [11:0] cfg_scaler;
   logic        irq;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;
   logic [7:0]  txq[$], rxq[$];

   always #10 clk = ~clk;

   sio_bus_front u0 (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
      #1;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge clk); penable = 1; #1 d = prdata;
      @(negedge clk); psel = 0; penable = 0;
      #1;
   endtask

   task automatic send(logic [7:0] b);   // driver: expected transmit order
      txq.push_back(b);
      wr(5'h00, {24'd0, b});
   endtask

   task automatic pop_tx(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tx_pop = 1;
         @(negedge clk); tx_pop = 0;
      end
      #1;
   endtask

   task automatic inject(logic [7:0] b, bit expect_kept);
      if (expect_kept) rxq.push_back(b);
      @(negedge clk); rx_push = 1; rx_byte = b;
      @(negedge clk); rx_push = 0;
      #1;
   endtask

   task automatic take_rx(string req);
      logic [31:0] d;
      rd(5'h00, d);
      chk(req, d, (rxq.size() != 0) ? {24'd0, rxq.pop_front()} : 32'd0);
   endtask

   // monitor: every byte the engine takes must be the next one written
   always @(posedge clk) begin
      if (rst_n && tx_pop && tx_avail) begin
         if (txq.size() == 0) chk("R2 R3 unexpected tx byte", {24'd0, tx_byte}, 32'hFFFF_FFFF);
         else                 chk("R2 R3 tx order", {24'd0, tx_byte}, {24'd0, txq.pop_front()});
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(5'h04, d); chk("R1 status", d, 32'h0000_0006);
      rd(5'h08, d); chk("R1 control", d, 32'h8000_0000);
      chk("R1 irq", {31'd0, irq}, 0);
      // R12 register readback
      wr(5'h0C, 32'hFFFF_FABC); rd(5'h0C, d); chk("R12 scaler", d, 32'h0000_0ABC);
      chk("R12 cfg_scaler", {20'd0, cfg_scaler}, 32'hABC);
      wr(5'h08, 32'h7FFF_7FFF); rd(5'h08, d); chk("R12 control", d, 32'h8000_7FFF);
      chk("R12 cfg_ctrl", {17'd0, cfg_ctrl}, 32'h7FFF);
      wr(5'h08, 0);
      // R2 short burst
      send(8'h11); send(8'h22); send(8'h33);
      rd(5'h04, d); chk("R2 tx count", d, 32'h0030_0002);
      pop_tx(3);
      rd(5'h04, d); chk("R2 drained", d, 32'h0000_0006);
      // R3 R7 overfill transmit side
      for (int i = 0; i < 8; i++) send(8'hA0 + 8'(i));
      rd(5'h04, d); chk("R3 R7 tx full", d, 32'h0080_0282);
      wr(5'h00, 32'hEE);   // dropped, not queued
      rd(5'h04, d); chk("R3 still full", d, 32'h0080_0282);
      pop_tx(8);
      chk("R3 nothing left", {31'd0, tx_avail}, 0);
      // R8 drain edge
      wr(5'h08, 32'h8);
      chk("R8 no pulse when idle", {31'd0, irq}, 0);
      send(8'h77); send(8'h78);
      pop_tx(1);
      chk("R8 no pulse with byte left", {31'd0, irq}, 0);
      @(negedge clk); tx_pop = 1;
      @(negedge clk); tx_pop = 0; #1;
      chk("R8 pulse", {31'd0, irq}, 1);
      @(negedge clk); #1;
      chk("R8 pulse one cycle", {31'd0, irq}, 0);
      wr(5'h08, 0);
      // R4 receive
      inject(8'h3C, 1); inject(8'hC3, 1);
      rd(5'h04, d); chk("R4 rx status", d, 32'h0800_0007);
      take_rx("R4 first"); take_rx("R4 second");
      take_rx("R4 empty read");
      rd(5'h04, d); chk("R4 ready cleared", d, 32'h0000_0006);
      // R9
      wr(5'h08, 32'h4);
      chk("R9 idle", {31'd0, irq}, 0);
      inject(8'h5D, 1);
      chk("R9 data present", {31'd0, irq}, 1);
      take_rx("R9 read");
      chk("R9 cleared", {31'd0, irq}, 0);
      wr(5'h08, 0);
      // R5 R7 overrun
      for (int i = 0; i < 8; i++) inject(8'h40 + 8'(i), 1);
      inject(8'hFF, 0);
      rd(5'h04, d); chk("R5 R7 rx full overrun", d, 32'h2000_0517);
      for (int i = 0; i < 8; i++) take_rx("R5 rx order");
      wr(5'h04, 0);
      rd(5'h04, d); chk("R5 overrun cleared", d, 32'h0000_0006);
      // R6 R10 error flags and break interrupt
      @(negedge clk); err_frame = 1; err_parity = 1; err_break = 1;
      @(negedge clk); err_frame = 0; err_parity = 0; err_break = 0;
      rd(5'h04, d); chk("R6 sticky errors", d, 32'h0000_006E);
      wr(5'h08, 32'h1000);
      chk("R10 break irq", {31'd0, irq}, 1);
      wr(5'h04, 0);
      rd(5'h04, d); chk("R6 cleared", d, 32'h0000_0006);
      chk("R10 break irq off", {31'd0, irq}, 0);
      // R10 transmit space and idle
      wr(5'h08, 32'h200);
      chk("R10 tx space", {31'd0, irq}, 1);
      for (int i = 0; i < 4; i++) send(8'h90 + 8'(i));
      chk("R10 tx half", {31'd0, irq}, 0);
      wr(5'h08, 32'h4000);
      chk("R10 idle with bytes", {31'd0, irq}, 0);
      pop_tx(4);
      chk("R10 idle", {31'd0, irq}, 1);
      // R10 receive threshold
      wr(5'h08, 32'h400);
      for (int i = 0; i < 3; i++) inject(8'h60 + 8'(i), 1);
      chk("R10 rx below half", {31'd0, irq}, 0);
      inject(8'h63, 1);
      chk("R10 rx half", {31'd0, irq}, 1);
      for (int i = 0; i < 4; i++) take_rx("R10 rx order");
      wr(5'h08, 0);
      // R11 debug write path
      wr(5'h10, 32'h5A);
      rd(5'h04, d); chk("R11 ignored without debug", d, 32'h0000_0006);
      wr(5'h08, 32'h800);
      rxq.push_back(8'hA5);
      wr(5'h10, 32'hA5);
      rd(5'h04, d); chk("R11 debug push", d, 32'h0400_0007);
      take_rx("R11 debug byte");
      chk("R2 tx queue empty", txq.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule